// File: doc/BRIEF.md
# Fixed-Frequency PWM Gate Pulse Generator

This block produces the drive signal for a switching regulator's power switch. A free-running period counter sets a fixed switching frequency. Each period opens with a short ramp-reset interval. During that interval a sync output is high and the gate is held low. After the interval, one gate pulse is issued whose width in clocks equals the duty command. The duty command is captured once at the start of the period and is capped at half the period.

The pulse is cut short at once by a cycle-by-cycle current-limit flag. Any cutting event, whether current limit, the halt input or undervoltage, keeps the gate off until the next period begins. This means a period never carries a second pulse. The halt input and the undervoltage flag both force the gate low. A rising edge on the external sync input is resynchronised and restarts the period. Several devices can therefore follow a master's sync output. For locking to work, the external rate must be at least 10% above the free-running rate.

All pins are plain level signals sampled every clock. There is no data stream and no handshake: the duty command is a static level that the block samples, so no back-pressure applies.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: While reset is low, `gate` is 0 and `sync_out` is 1. The captured duty resets to zero, so the first period after reset issues no pulse.
- R2: With no external edge, a period lasts exactly PERIOD clocks. `sync_out` is high for the first RST_CYC clocks of each period and low for the rest.
- R3: The gate goes high at clock RST_CYC of the period (counting from 0) and stays high for exactly D clocks. D is the duty command captured on the clock that starts the period. D = 0 gives no pulse.
- R4: D is saturated to PERIOD/2, so a command above PERIOD/2 yields a pulse of PERIOD/2 clocks.
- R5: A change of the duty command during a period does not alter that period's pulse. It takes effect from the next period.
- R6: When `cur_lim` is 1, `gate` is 0 in the same cycle. The gate stays 0 for the rest of the period even after `cur_lim` returns to 0, and the next period pulses normally.
- R7: At most one gate pulse occurs per period. A pulse can begin only at clock RST_CYC, and any of `cur_lim`, `halt` or `uv_flag` seen from clock RST_CYC onward ends the pulse for the period.
- R8: While `halt` is 1, `gate` is 0.
- R9: While `uv_flag` is 1, `gate` is 0.
- R10: A rising edge of `ext_sync` passes through a two-flop synchronizer and an edge detector. A level change that is set up before clock edge k makes the counter restart on edge k+2, so `sync_out` is 1 after edge k+2. Repeated edges faster than the free-running rate set the period length.
- R11: `gate` is never 1 while `sync_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_cmd | input | $clog2(PERIOD) | Pulse width command in clocks, captured at period start |
| cur_lim | input | 1 | Cycle-by-cycle current-limit flag, 1 = over current |
| halt | input | 1 | 1 forces the gate off |
| uv_flag | input | 1 | 1 = supply undervoltage, gate inhibited |
| ext_sync | input | 1 | Asynchronous external sync; rising edge restarts the period |
| gate | output | 1 | Gate drive pulse |
| sync_out | output | 1 | High during the ramp-reset interval of each period |

## Verification
The hardest case to reach is a gate-off cause that appears in the middle of a pulse and then clears before the window would have closed. The bench must show that the gate does not come back on in that period and does come back in the next. Each scenario waits for the rising edge of `sync_out` to find clock 0 of a period. It then counts negative edges to apply `cur_lim`, `halt` or a new duty value at a chosen clock, and measures the gate width and the number of pulses over the whole period. External sync is placed the same way, a known number of clocks into the period, to pin down the restart latency. A background driver then repeats the edge every 16 clocks to show the period follows it.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  // Saturate a requested width to a ceiling.
  function automatic int unsigned clamp_u(input int unsigned req, input int unsigned ceil_v);
    return (req > ceil_v) ? ceil_v : req;
  endfunction
endpackage

// File: rtl/pwm_sync_edge.sv
module pwm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int PERIOD  = 100,
  parameter int RST_CYC = 4,
  parameter int CNT_W   = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             in_reset
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] RST_N = CNT_W'(RST_CYC);

  // wrap marks the clock edge that begins a new period
  assign wrap     = restart | (cnt == LAST);
  assign in_reset = (cnt < RST_N);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_pulse_gate.sv
module pwm_pulse_gate #(
  parameter int CNT_W    = 7,
  parameter int RST_CYC  = 4,
  parameter int MAX_DUTY = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic             cur_lim,
  input  logic             halt,
  input  logic             uv_flag,
  output logic             gate
);
  localparam logic [CNT_W:0] WIN_START = (CNT_W+1)'(RST_CYC);

  logic [CNT_W-1:0] duty_q;
  logic             kill_q;
  logic [CNT_W:0]   win_end;
  logic             past_start;
  logic             in_win;
  logic             block;

  assign win_end    = {1'b0, duty_q} + WIN_START;
  assign past_start = ({1'b0, cnt} >= WIN_START);
  assign in_win     = past_start && ({1'b0, cnt} < win_end);
  assign block      = cur_lim | halt | uv_flag;

  // Duty is captured on the period boundary only, saturated to the ceiling
  always_ff @(posedge clk) begin
    if (!rst_n)    duty_q <= '0;
    else if (wrap) duty_q <= CNT_W'(pwm_gate_pkg::clamp_u(32'(duty_cmd), MAX_DUTY));
  end

  // Once a gate-off cause is seen after the window opens, stay off for the period
  always_ff @(posedge clk) begin
    if (!rst_n)                   kill_q <= 1'b0;
    else if (wrap)                kill_q <= 1'b0;
    else if (past_start && block) kill_q <= 1'b1;
  end

  // Current limit acts combinationally so the cut is immediate
  assign gate = in_win & ~kill_q & ~block;
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl #(
  parameter int PERIOD      = 100,
  parameter int RST_CYC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DUTY_W      = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic              cur_lim,
  input  logic              halt,
  input  logic              uv_flag,
  input  logic              ext_sync,
  output logic              gate,
  output logic              sync_out
);
  localparam int CNT_W    = DUTY_W;
  localparam int MAX_DUTY = PERIOD / 2;

  logic             ext_rise;
  logic             wrap;
  logic [CNT_W-1:0] cnt;

  pwm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_sync),
    .rise     (ext_rise)
  );

  pwm_period_timer #(.PERIOD(PERIOD), .RST_CYC(RST_CYC), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ext_rise),
    .cnt      (cnt),
    .wrap     (wrap),
    .in_reset (sync_out)
  );

  pwm_pulse_gate #(.CNT_W(CNT_W), .RST_CYC(RST_CYC), .MAX_DUTY(MAX_DUTY)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap),
    .cnt      (cnt),
    .duty_cmd (duty_cmd),
    .cur_lim  (cur_lim),
    .halt     (halt),
    .uv_flag  (uv_flag),
    .gate     (gate)
  );
endmodule

// File: rtl/pwm_gate_ctrl_chk.sv
module pwm_gate_ctrl_chk #(
  parameter int PERIOD = 100
) (
  input logic clk,
  input logic rst_n,
  input logic cur_lim,
  input logic halt,
  input logic uv_flag,
  input logic gate,
  input logic sync_out
);
  logic [15:0] hi_cnt;
  logic [15:0] since_start;
  logic        prev_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt      <= '0;
      since_start <= '0;
      prev_sync   <= 1'b1;
    end else begin
      prev_sync <= sync_out;
      if (sync_out)  hi_cnt <= '0;
      else if (gate) hi_cnt <= hi_cnt + 1'b1;
      if (sync_out && !prev_sync) since_start <= '0;
      else                        since_start <= since_start + 1'b1;
    end
  end

  // R11
  sync_gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) sync_out |-> !gate);
  // R8
  halt_off_chk: assert property (@(posedge clk) disable iff (!rst_n) halt |-> !gate);
  // R9
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n) uv_flag |-> !gate);
  // R6
  cur_lim_off_chk: assert property (@(posedge clk) disable iff (!rst_n) cur_lim |-> !gate);
  // R7
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate) |-> $past(sync_out));
  // R4
  duty_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n) hi_cnt <= 16'(PERIOD / 2));
  // R2
  period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) since_start <= 16'(PERIOD));
endmodule

bind pwm_gate_ctrl pwm_gate_ctrl_chk #(.PERIOD(PERIOD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cur_lim  (cur_lim),
  .halt     (halt),
  .uv_flag  (uv_flag),
  .gate     (gate),
  .sync_out (sync_out)
);

// File: tb/pwm_gate_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_gate_ctrl_bench;
  localparam int BP  = 20;
  localparam int BR  = 2;
  localparam int DW  = $clog2(BP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] duty_cmd = '0;
  logic          cur_lim = 1'b0;
  logic          halt = 1'b0;
  logic          uv_flag = 1'b0;
  logic          ext_sync = 1'b0;
  logic          gate;
  logic          sync_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_gate_ctrl #(.PERIOD(BP), .RST_CYC(BR)) u_pwm_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .cur_lim(cur_lim),
    .halt(halt), .uv_flag(uv_flag), .ext_sync(ext_sync),
    .gate(gate), .sync_out(sync_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Returns at the negedge where the period counter is 0
  task automatic wait_start();
    logic prev;
    prev = sync_out;
    forever begin
      @(negedge clk); #1;
      if (sync_out && !prev) break;
      prev = sync_out;
    end
  endtask

  // kind: 0 none, 1 duty change, 2 cur_lim, 3 halt, 4 uv_flag
  task automatic measure(input int kind, input int at, input int len, input int val,
                         output int hi, output int rises, output int g_ev, output int ovl,
                         output int sync_hi);
    logic pg;
    pg = 1'b0; hi = 0; rises = 0; g_ev = -1; ovl = 0; sync_hi = 0;
    for (int i = 0; i < BP; i++) begin
      if (i > 0) begin @(negedge clk); #1; end
      if (i == at) begin
        case (kind)
          1: duty_cmd = DW'(val);
          2: cur_lim = 1'b1;
          3: halt = 1'b1;
          4: uv_flag = 1'b1;
          default: ;
        endcase
        #0.5;
        g_ev = int'(gate);
      end
      if (i == at + len && kind > 1) begin
        cur_lim = 1'b0; halt = 1'b0; uv_flag = 1'b0; #0.5;
      end
      if (gate) hi++;
      if (gate && !pg) rises++;
      if (gate && sync_out) ovl++;
      if (sync_out) sync_hi++;
      pg = gate;
    end
    cur_lim = 1'b0; halt = 1'b0; uv_flag = 1'b0;
  endtask

  task automatic t_reset();
    duty_cmd = DW'(5);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(gate == 1'b0, "R1 gate in reset", int'(gate), 0);
    check(sync_out == 1'b1, "R1 sync_out in reset", int'(sync_out), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(sync_out == 1'b1, "R1 sync_out after release", int'(sync_out), 1);
    @(negedge clk); #1;
    check(gate == 1'b0, "R1 no pulse in first period", int'(gate), 0);
  endtask

  task automatic t_width(input int d);
    int hi, ri, ge, ov, sh;
    duty_cmd = DW'(d);
    wait_start();
    measure(0, -1, 0, 0, hi, ri, ge, ov, sh);
    check(hi == d, "R3 pulse width", hi, d);
    check(ri == ((d > 0) ? 1 : 0), "R7 pulse count", ri, (d > 0) ? 1 : 0);
    check(ov == 0, "R11 gate during sync_out", ov, 0);
  endtask

  task automatic t_period();
    int n, hi, ri, ge, ov, sh;
    wait_start();
    n = 0;
    begin
      logic prev;
      prev = sync_out;
      forever begin
        @(negedge clk); #1; n++;
        if (sync_out && !prev) break;
        prev = sync_out;
      end
    end
    check(n == BP, "R2 period length", n, BP);
    measure(0, -1, 0, 0, hi, ri, ge, ov, sh);
    check(sh == BR, "R2 sync_out high clocks", sh, BR);
  endtask

  task automatic t_clamp(input int d);
    int hi, ri, ge, ov, sh;
    duty_cmd = DW'(d);
    wait_start();
    measure(0, -1, 0, 0, hi, ri, ge, ov, sh);
    check(hi == BP / 2, "R4 clamped width", hi, BP / 2);
  endtask

  task automatic t_midchange();
    int hi, ri, ge, ov, sh;
    duty_cmd = DW'(6);
    wait_start();
    measure(1, 4, 0, 9, hi, ri, ge, ov, sh);
    check(hi == 6, "R5 width unchanged mid period", hi, 6);
    wait_start();
    measure(0, -1, 0, 0, hi, ri, ge, ov, sh);
    check(hi == 9, "R5 new width next period", hi, 9);
  endtask

  task automatic t_curlim();
    int hi, ri, ge, ov, sh;
    duty_cmd = DW'(8);
    wait_start();
    measure(2, 4, 1, 0, hi, ri, ge, ov, sh);
    check(ge == 0, "R6 immediate cut", ge, 0);
    check(hi == 2, "R6 stays off after release", hi, 2);
    check(ri == 1, "R7 one pulse with current limit", ri, 1);
    wait_start();
    measure(0, -1, 0, 0, hi, ri, ge, ov, sh);
    check(hi == 8, "R6 next period recovers", hi, 8);
  endtask

  task automatic t_halt_glitch();
    int hi, ri, ge, ov, sh;
    duty_cmd = DW'(8);
    wait_start();
    measure(3, 5, 1, 0, hi, ri, ge, ov, sh);
    check(hi == 3, "R7 halt glitch ends pulse", hi, 3);
    check(ri == 1, "R7 no second pulse", ri, 1);
  endtask

  task automatic t_hold(input int kind);
    int hi, ri, ge, ov, sh;
    duty_cmd = DW'(8);
    wait_start();
    measure(kind, 0, BP, 0, hi, ri, ge, ov, sh);
    if (kind == 3) check(hi == 0, "R8 halt forces gate low", hi, 0);
    else           check(hi == 0, "R9 undervoltage forces gate low", hi, 0);
  endtask

  task automatic t_extsync();
    int n;
    duty_cmd = DW'(5);
    wait_start();
    repeat (12) @(negedge clk);
    ext_sync = 1'b1;
    @(negedge clk); #1;
    @(negedge clk); #1;
    check(sync_out == 1'b0, "R10 no restart before latency", int'(sync_out), 0);
    @(negedge clk); #1;
    check(sync_out == 1'b1, "R10 restart after two-flop sync", int'(sync_out), 1);
    ext_sync = 1'b0;
    repeat (BP) @(negedge clk);
    fork
      begin
        for (int k = 0; k < 6; k++) begin
          ext_sync = 1'b1;
          repeat (4) @(negedge clk);
          ext_sync = 1'b0;
          repeat (12) @(negedge clk);
        end
      end
    join_none
    wait_start();
    wait_start();
    n = 0;
    begin
      logic prev;
      prev = sync_out;
      forever begin
        @(negedge clk); #1; n++;
        if (sync_out && !prev) break;
        prev = sync_out;
      end
    end
    check(n == 16, "R10 period follows external edges", n, 16);
    repeat (80) @(negedge clk);
    ext_sync = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_width(5);
    t_width(0);
    t_width(7);
    t_period();
    t_clamp(15);
    t_clamp(31);
    t_midchange();
    t_curlim();
    t_halt_glitch();
    t_hold(3);
    t_hold(4);
    t_extsync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule